// File: doc/BRIEF.md
# Serial Baud Tick Generator

This block produces the bit-period timing shared by a serial transmitter and receiver. It runs entirely on the system clock. Its outputs are single-cycle enable pulses, not derived clocks. It can count from one of three sources: every system clock cycle, every eighth system clock cycle, or each rising edge of an external serial clock pin. That pin is synchronized into the system clock domain before it is used.

In asynchronous mode the selected source is divided by the programmed divisor to form an oversampling tick for the receiver. Sixteen of those oversampling ticks make one baud tick. In synchronous mode with an internal source, the baud tick is the source divided by the divisor alone. In synchronous mode with the external source, every detected rising edge of the pin is a baud tick, and the divisor plays no part. Whenever division is in use, a divisor of zero silences both outputs. Any change to the configuration restarts the counting chain from zero.

The external clock must hold each level for longer than one system clock period. Its frequency must be at most one part in 2.5 of the system clock frequency.

Top module: `serial_baud_gen`

## Requirements
- R1: While reset is asserted, and for as long as the divisor stays zero after reset, both `baud_tick_o` and `os_tick_o` stay low.
- R2: With `clk_sel_i` = 2'b00 (every system clock cycle) in synchronous mode with divisor D > 0, `baud_tick_o` pulses once every D system clock cycles.
- R3: With `clk_sel_i` = 2'b01 (system clock divided by 8), the source advances once every 8 system clock cycles. In synchronous mode with divisor D > 0, the baud period is 8·D cycles.
- R4: When `clk_sel_i[1]` = 1, the source is the rising edges of `ext_clk_i` after a two-flop synchronizer. In synchronous mode, each rising edge gives exactly one baud tick, whatever the divisor (zero included) and whatever `clk_sel_i[0]`.
- R5: In asynchronous mode (`sync_mode_i` = 0) with divisor D > 0 and source period N cycles, `os_tick_o` pulses every D·N cycles. `baud_tick_o` pulses every 16·D·N cycles, and each baud tick coincides with an oversampling tick. There are 16 oversampling ticks per baud period.
- R6: In synchronous mode, `os_tick_o` never pulses.
- R7: A divisor of zero, in any configuration other than synchronous mode with the external source, produces no ticks on either output.
- R8: A divisor of 1 in synchronous mode with `clk_sel_i` = 2'b00 makes `baud_tick_o` high on every cycle.
- R9: A change of divisor, mode or source reloads every counter to zero and suppresses ticks in the cycle of the change. The first new baud tick appears one full period P after the clock edge that registers the change: it is visible at the (P+1)-th falling edge, counting the falling edge at which the new value was driven as zero.
- R10: The full 16-bit divisor range is supported: divisor 16'hFFFF with `clk_sel_i` = 2'b00 in synchronous mode gives a period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External serial clock pin, asynchronous to `clk` |
| clk_sel_i | input | 2 | Source select: 00 system clock, 01 system clock / 8, 1x external pin |
| sync_mode_i | input | 1 | 1 = synchronous mode, 0 = asynchronous (16x oversampled) mode |
| divisor_i | input | 16 | Programmed divisor; 0 disables the output whenever division is active |
| baud_tick_o | output | 1 | One-cycle baud tick enable |
| os_tick_o | output | 1 | One-cycle oversampling tick enable (asynchronous mode only) |

## Verification
The bench builds the block with its default 16-bit divisor, so the extreme divisor 16'hFFFF is measured as a real 65535-cycle period. It sweeps small divisors (0, 1, 2, 3, 4, 5, 7) across every source and both modes. The external pin is driven with a 6-cycle period, which meets the validity limits and still keeps asynchronous external cases within a few hundred cycles per baud period. Latency after each reconfiguration, the spacing between ticks, and the number of oversampling ticks per baud period are all compared with values the bench computes from the source period, the divisor and the mode.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    // Source select encoding (bit 1 picks the external pin).
    typedef enum logic [1:0] {
        SRC_SYS      = 2'b00,
        SRC_SYS_DIV8 = 2'b01,
        SRC_EXT      = 2'b10,
        SRC_EXT_ALT  = 2'b11
    } clk_src_e;

    localparam int unsigned OS_FACTOR   = 16;
    localparam int unsigned PRE_FACTOR  = 8;
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/bg_edge_sync.sv
module bg_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } state_t;

    state_t d, q;

    always_comb begin
        d = q;
        d.chain = {q.chain[STAGES-1:0], pin_i};
        rise_o  = q.chain[STAGES-1] & ~q.chain[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R4

endmodule

// File: rtl/bg_prescale.sv
module bg_prescale #(
    parameter int unsigned FACTOR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_i,
    output logic en_o
);
    localparam int unsigned W = $clog2(FACTOR);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t d, q;

    always_comb begin
        d    = q;
        en_o = (q.cnt == W'(FACTOR - 1));
        if (reload_i)  d.cnt = '0;
        else if (en_o) d.cnt = '0;
        else           d.cnt = q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o); // R3

endmodule

// File: rtl/bg_divider.sv
module bg_divider #(
    parameter int unsigned DIV_W     = 16,
    parameter int unsigned OS_FACTOR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             step_i,
    input  logic             async_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             cnt_hit_o,
    output logic             frame_hit_o
);
    localparam int unsigned OS_W = $clog2(OS_FACTOR);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [OS_W-1:0]  os;
    } state_t;

    state_t d, q;
    logic   active;

    always_comb begin
        d           = q;
        cnt_hit_o   = 1'b0;
        frame_hit_o = 1'b0;
        active      = step_i && (divisor_i != '0);
        if (reload_i) begin
            d.cnt = '0;
            d.os  = '0;
        end else if (active) begin
            if (q.cnt == divisor_i - DIV_W'(1)) begin
                d.cnt     = '0;
                cnt_hit_o = 1'b1;
                if (async_i) begin
                    if (q.os == OS_W'(OS_FACTOR - 1)) begin
                        d.os        = '0;
                        frame_hit_o = 1'b1;
                    end else begin
                        d.os = q.os + OS_W'(1);
                    end
                end else begin
                    frame_hit_o = 1'b1;
                end
            end else begin
                d.cnt = q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor_i != '0) |-> (q.cnt < divisor_i)); // R2

endmodule

// File: rtl/serial_baud_gen.sv
module serial_baud_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [1:0]       clk_sel_i,
    input  logic             sync_mode_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             baud_tick_o,
    output logic             os_tick_o
);
    import baudgen_pkg::*;

    typedef struct packed {
        logic [1:0]       sel;
        logic             sync;
        logic [DIV_W-1:0] div;
        logic             baud;
        logic             os;
    } state_t;

    state_t d, q;

    logic cfg_chg;
    logic ext_rise;
    logic pre_en;
    logic step;
    logic ext_direct;
    logic cnt_hit;
    logic frame_hit;

    bg_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_i),
        .rise_o (ext_rise)
    );

    bg_prescale #(.FACTOR(PRE_FACTOR)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (cfg_chg),
        .en_o     (pre_en)
    );

    bg_divider #(.DIV_W(DIV_W), .OS_FACTOR(OS_FACTOR)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_i    (cfg_chg),
        .step_i      (step),
        .async_i     (!q.sync),
        .divisor_i   (q.div),
        .cnt_hit_o   (cnt_hit),
        .frame_hit_o (frame_hit)
    );

    always_comb begin
        d       = q;
        cfg_chg = (clk_sel_i != q.sel) || (sync_mode_i != q.sync) ||
                  (divisor_i != q.div);
        ext_direct = q.sync && q.sel[1];
        case (clk_src_e'(q.sel))
            SRC_SYS:      step = 1'b1;
            SRC_SYS_DIV8: step = pre_en;
            default:      step = ext_rise;
        endcase
        d.sel  = clk_sel_i;
        d.sync = sync_mode_i;
        d.div  = divisor_i;
        d.baud = !cfg_chg && (ext_direct ? ext_rise : frame_hit);
        d.os   = !cfg_chg && !q.sync && cnt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign baud_tick_o = q.baud;
    assign os_tick_o   = q.os;

    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (!baud_tick_o && !os_tick_o)); // R9
    AST_OS_ASYNC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick_o |-> !q.sync); // R6
    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.div == '0) && !(q.sync && q.sel[1])) |=> !baud_tick_o); // R7
    AST_ASYNC_TICK_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick_o && !q.sync) |-> os_tick_o); // R5

endmodule

// File: tb/serial_baud_gen_tb.sv
module serial_baud_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk = 1'b0;
    logic [1:0]  sel = 2'b00;
    logic        sm = 1'b0;
    logic [15:0] dv = 16'd0;
    logic        baud_tick_o;
    logic        os_tick_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    // External clock: 6 system cycles per period.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            ext_clk = ~ext_clk;
        end
    end

    serial_baud_gen #(.DIV_W(16)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_i   (ext_clk),
        .clk_sel_i   (sel),
        .sync_mode_i (sm),
        .divisor_i   (dv),
        .baud_tick_o (baud_tick_o),
        .os_tick_o   (os_tick_o)
    );

    task automatic check(input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", name, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic m, input logic [15:0] d);
        @(negedge clk);
        sel = s;
        sm  = m;
        dv  = d;
    endtask

    task automatic wait_tick(input int limit, output int n, output int osn);
        n = 0;
        osn = 0;
        do begin
            @(negedge clk);
            n++;
            if (os_tick_o) osn++;
        end while (!baud_tick_o && n < limit);
        if (!baud_tick_o) n = -1;
    endtask

    task automatic run_case(input string req, input logic [1:0] s, input logic m,
                            input logic [15:0] d, input int per, input bit lat);
        int n;
        int o;
        apply(s, m, d);
        wait_tick(3 * per + 50, n, o);
        if (lat) check({req, " latency (R9)"}, n, per + 1);
        for (int i = 0; i < 2; i++) begin
            wait_tick(2 * per + 50, n, o);
            check({req, " period"}, n, per);
            if (m) check({req, " R6 os count"}, o, 0);
            else   check({req, " R5 os count"}, o, 16);
        end
    endtask

    task automatic run_silent(input string req, input logic [1:0] s, input logic m,
                              input logic [15:0] d, input int len);
        int nb = 0;
        int no = 0;
        apply(s, m, d);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (baud_tick_o) nb++;
            if (os_tick_o) no++;
        end
        check({req, " baud ticks"}, nb, 0);
        check({req, " os ticks"}, no, 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        int o;
        // R1: reset state and idle after reset with divisor 0
        repeat (3) @(negedge clk);
        check("R1 baud in reset", int'(baud_tick_o), 0);
        check("R1 os in reset", int'(os_tick_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check("R1 baud idle", int'(baud_tick_o), 0);
        check("R1 os idle", int'(os_tick_o), 0);

        // R2 / R8: system clock, synchronous
        run_case("R8 sys sync D1", 2'b00, 1'b1, 16'd1, 1, 1'b1);
        run_case("R2 sys sync D2", 2'b00, 1'b1, 16'd2, 2, 1'b1);
        run_case("R2 sys sync D5", 2'b00, 1'b1, 16'd5, 5, 1'b1);
        // R5: system clock, asynchronous
        run_case("R5 sys async D1", 2'b00, 1'b0, 16'd1, 16, 1'b1);
        run_case("R5 sys async D3", 2'b00, 1'b0, 16'd3, 48, 1'b1);
        // R3: system clock / 8
        run_case("R3 div8 sync D1", 2'b01, 1'b1, 16'd1, 8, 1'b1);
        run_case("R3 div8 sync D4", 2'b01, 1'b1, 16'd4, 32, 1'b1);
        run_case("R3 div8 async D2", 2'b01, 1'b0, 16'd2, 256, 1'b1);
        // R4: external pin
        run_case("R4 ext sync sel10 D7", 2'b10, 1'b1, 16'd7, 6, 1'b0);
        run_case("R4 ext sync sel11 D0", 2'b11, 1'b1, 16'd0, 6, 1'b0);
        run_case("R5 ext async D2", 2'b10, 1'b0, 16'd2, 192, 1'b0);
        // R7: zero divisor silences divided configurations
        run_silent("R7 sys sync D0", 2'b00, 1'b1, 16'd0, 300);
        run_silent("R7 div8 async D0", 2'b01, 1'b0, 16'd0, 600);
        run_silent("R7 ext async D0", 2'b11, 1'b0, 16'd0, 600);
        // R9: reconfigure mid-run, then restart
        run_case("R9 sys sync D3 after zero", 2'b00, 1'b1, 16'd3, 3, 1'b1);
        // R10: maximum divisor, latency after change
        apply(2'b00, 1'b1, 16'hFFFF);
        wait_tick(70000, n, o);
        check("R10 max divisor latency", n, 65536);
        check("R10 R6 os count", o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule